// File: doc/BRIEF.md
# Channel Event Status Bank with Sticky Overflow

This block holds the event flags of a multi-channel timer coprocessor. Each channel has two request flags, one for interrupts and one for data transfers. Each request flag has a sticky overflow companion. The overflow bit records that a new request pulse arrived while the request flag was still pending. A small set of global exception sources also latches here. Each source keeps its own bit, and one level output reports whether any of them is set.

Set pulses arrive from the microengine side, one bit per channel. The host clears flags through a simple register port using write-one-to-clear. It reads the flags back in two ways: as one status word per channel, or as 32-bit mirror words that carry one bit per channel for each kind of flag. Two level outputs summarise whether any channel has a pending interrupt or a pending data transfer request. A fixed rule settles a set pulse and a host clear that land in the same cycle.

Top module: `evt_stat_top`

## Requirements
- R1: After reset every status, overflow and exception bit is 0, every readable word reads 0, and `irq_any_o`, `dtr_any_o` and `gexc_o` are low.
- R2: A set pulse on a channel sets its request flag on the next clock edge. Word address n (0 to N_CH-1) returns channel n with these fields: bit 0 is the interrupt status, bit 1 the interrupt overflow, bit 2 the transfer status and bit 3 the transfer overflow. A read issued on one edge returns its data with `host_rvalid_o` high after that edge.
- R3: A set pulse that arrives while the flag is already set, and is not accompanied by a clear, sets that flag's overflow bit. A set pulse on a clear flag leaves the overflow bit at 0.
- R4: Clearing a request flag leaves its overflow bit unchanged. The overflow bit is cleared only by writing 1 to its own bit.
- R5: When a set pulse and a host clear of the same request flag fall in the same cycle, the flag ends up at 1. The flag's overflow bit keeps its previous value, even when the same write also tries to clear that overflow bit.
- R6: Writing 0 to a bit of any register leaves that bit unchanged.
- R7: The mirror words have one bit per channel, with bit n for channel n. Address 0x20 holds interrupt status, 0x21 interrupt overflow, 0x22 transfer status and 0x23 transfer overflow. Writing 1 to bit n of a mirror word clears that bit for channel n.
- R8: Transfer request flags follow the same set, overflow and clear rules as interrupt flags, and the two kinds are independent of each other.
- R9: Address 0x24 holds one bit per exception source in bits N_SRC-1:0, and the other bits read 0. Any combination of sources can be set at once, and each is cleared by writing 1 to its bit. A source pulse wins over a clear in the same cycle. `gexc_o` is high while any source bit is set. The exception bits have no overflow bits.
- R10: `irq_any_o` is high while any channel's interrupt status is set, and `dtr_any_o` is high while any channel's transfer status is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_set_i | input | N_CH | Interrupt set pulses, one per channel |
| dtr_set_i | input | N_CH | Data transfer request set pulses, one per channel |
| gexc_src_i | input | N_SRC | Global exception source pulses |
| host_wr_i | input | 1 | Host write strobe (write-one-to-clear) |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 6 | Host word address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data, registered |
| host_rvalid_o | output | 1 | Read data valid |
| irq_any_o | output | 1 | Any channel interrupt status set |
| dtr_any_o | output | 1 | Any channel transfer status set |
| gexc_o | output | 1 | Any global exception source set |

## Verification
The assertions assume that the set inputs and the host strobes are valid on every clock edge after reset. They also assume that a host write and a host read never target the same cycle in a way that needs read-after-write forwarding. The stimulus drives every input to a known value from time zero and changes inputs only at falling edges. It issues each read in a cycle of its own, after the pulses and writes it depends on. The same-cycle cases are built by raising a set pulse and a host write together for exactly one cycle.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int MAX_CH = 32;

  // per-channel word fields
  localparam int B_IRQ_ST = 0;
  localparam int B_IRQ_OV = 1;
  localparam int B_DTR_ST = 2;
  localparam int B_DTR_OV = 3;

  // mirror and exception words
  localparam logic [ADDR_W-1:0] A_IRQ_ST = 6'h20;
  localparam logic [ADDR_W-1:0] A_IRQ_OV = 6'h21;
  localparam logic [ADDR_W-1:0] A_DTR_ST = 6'h22;
  localparam logic [ADDR_W-1:0] A_DTR_OV = 6'h23;
  localparam logic [ADDR_W-1:0] A_GEXC   = 6'h24;

  typedef struct packed {
    logic st_clr;
    logic ov_clr;
  } clr_pair_t;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] st_clr_i,
  input  logic [N-1:0] ov_clr_i,
  output logic [N-1:0] st_o,
  output logic [N-1:0] ov_o
);
  logic [N-1:0] st_q, ov_q, st_d, ov_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic hold;
    logic ov_hit;
    assign hold   = set_i[i] & st_clr_i[i];
    assign ov_hit = set_i[i] & st_q[i] & ~st_clr_i[i];
    assign st_d[i] = set_i[i] | (st_q[i] & ~st_clr_i[i]);
    // set+clear together: overflow frozen; otherwise overflow set beats its clear
    assign ov_d[i] = hold ? ov_q[i] : (ov_hit | (ov_q[i] & ~ov_clr_i[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      ov_q <= '0;
    end else begin
      st_q <= st_d;
      ov_q <= ov_d;
    end
  end

  assign st_o = st_q;
  assign ov_o = ov_q;

  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~st_q) == '0));

  p_ovf_on_reissue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i & st_q & ~st_clr_i) & ~ov_q) == '0));

  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ov_q & ~ov_clr_i) & ~ov_q) == '0));

  p_same_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i & st_clr_i) & (ov_q ^ $past(ov_q))) == '0));
endmodule

// File: rtl/evt_gexc.sv
module evt_gexc #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] src_o,
  output logic             gexc_o
);
  logic [N_SRC-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i | (src_q & ~clr_i);
  end

  assign src_o  = src_q;
  assign gexc_o = |src_q;

  p_src_latch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(src_i) & ~src_q) == '0));

  p_src_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(src_q & ~clr_i) & ~src_q) == '0));
endmodule

// File: rtl/evt_host_regs.sv
module evt_host_regs
  import evt_stat_pkg::*;
#(
  parameter int N_CH  = 32,
  parameter int N_SRC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [N_CH-1:0]   irq_st_i,
  input  logic [N_CH-1:0]   irq_ov_i,
  input  logic [N_CH-1:0]   dtr_st_i,
  input  logic [N_CH-1:0]   dtr_ov_i,
  input  logic [N_SRC-1:0]  gexc_src_i,
  output logic [N_CH-1:0]   irq_st_clr_o,
  output logic [N_CH-1:0]   irq_ov_clr_o,
  output logic [N_CH-1:0]   dtr_st_clr_o,
  output logic [N_CH-1:0]   dtr_ov_clr_o,
  output logic [N_SRC-1:0]  gexc_clr_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o
);
  logic [MAX_CH-1:0] irq_st_w, irq_ov_w, dtr_st_w, dtr_ov_w;
  logic [DATA_W-1:0] gexc_w, rd_word, rdata_q;
  logic              rvalid_q;
  logic              wr_irq_st, wr_irq_ov, wr_dtr_st, wr_dtr_ov, wr_gexc;

  assign irq_st_w = MAX_CH'(irq_st_i);
  assign irq_ov_w = MAX_CH'(irq_ov_i);
  assign dtr_st_w = MAX_CH'(dtr_st_i);
  assign dtr_ov_w = MAX_CH'(dtr_ov_i);
  assign gexc_w   = DATA_W'(gexc_src_i);

  assign wr_irq_st = host_wr_i && (host_addr_i == A_IRQ_ST);
  assign wr_irq_ov = host_wr_i && (host_addr_i == A_IRQ_OV);
  assign wr_dtr_st = host_wr_i && (host_addr_i == A_DTR_ST);
  assign wr_dtr_ov = host_wr_i && (host_addr_i == A_DTR_OV);
  assign wr_gexc   = host_wr_i && (host_addr_i == A_GEXC);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic      ch_hit;
    clr_pair_t irq_c, dtr_c;
    assign ch_hit       = host_wr_i && (host_addr_i == ADDR_W'(c));
    assign irq_c.st_clr = (ch_hit & host_wdata_i[B_IRQ_ST]) | (wr_irq_st & host_wdata_i[c]);
    assign irq_c.ov_clr = (ch_hit & host_wdata_i[B_IRQ_OV]) | (wr_irq_ov & host_wdata_i[c]);
    assign dtr_c.st_clr = (ch_hit & host_wdata_i[B_DTR_ST]) | (wr_dtr_st & host_wdata_i[c]);
    assign dtr_c.ov_clr = (ch_hit & host_wdata_i[B_DTR_OV]) | (wr_dtr_ov & host_wdata_i[c]);
    assign irq_st_clr_o[c] = irq_c.st_clr;
    assign irq_ov_clr_o[c] = irq_c.ov_clr;
    assign dtr_st_clr_o[c] = dtr_c.st_clr;
    assign dtr_ov_clr_o[c] = dtr_c.ov_clr;
  end

  assign gexc_clr_o = wr_gexc ? host_wdata_i[N_SRC-1:0] : '0;

  always_comb begin
    rd_word = '0;
    if (host_addr_i < ADDR_W'(N_CH)) begin
      rd_word[B_IRQ_ST] = irq_st_w[host_addr_i[4:0]];
      rd_word[B_IRQ_OV] = irq_ov_w[host_addr_i[4:0]];
      rd_word[B_DTR_ST] = dtr_st_w[host_addr_i[4:0]];
      rd_word[B_DTR_OV] = dtr_ov_w[host_addr_i[4:0]];
    end else begin
      case (host_addr_i)
        A_IRQ_ST: rd_word = irq_st_w;
        A_IRQ_OV: rd_word = irq_ov_w;
        A_DTR_ST: rd_word = dtr_st_w;
        A_DTR_OV: rd_word = dtr_ov_w;
        A_GEXC:   rd_word = gexc_w;
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_rd_i;
      if (host_rd_i) rdata_q <= rd_word;
    end
  end

  assign host_rdata_o  = rdata_q;
  assign host_rvalid_o = rvalid_q;

  p_rvalid_follows_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i |=> host_rvalid_o);

  p_rdata_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> $stable(host_rdata_o));
endmodule

// File: rtl/evt_stat_top.sv
module evt_stat_top
  import evt_stat_pkg::*;
#(
  parameter int N_CH  = 32,
  parameter int N_SRC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   irq_set_i,
  input  logic [N_CH-1:0]   dtr_set_i,
  input  logic [N_SRC-1:0]  gexc_src_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o,
  output logic              irq_any_o,
  output logic              dtr_any_o,
  output logic              gexc_o
);
  logic [N_CH-1:0]  irq_st, irq_ov, dtr_st, dtr_ov;
  logic [N_CH-1:0]  irq_st_clr, irq_ov_clr, dtr_st_clr, dtr_ov_clr;
  logic [N_SRC-1:0] gexc_q, gexc_clr;

  evt_flag_bank #(.N(N_CH)) u_irq (
    .clk_i, .rst_ni,
    .set_i(irq_set_i), .st_clr_i(irq_st_clr), .ov_clr_i(irq_ov_clr),
    .st_o(irq_st), .ov_o(irq_ov)
  );

  evt_flag_bank #(.N(N_CH)) u_dtr (
    .clk_i, .rst_ni,
    .set_i(dtr_set_i), .st_clr_i(dtr_st_clr), .ov_clr_i(dtr_ov_clr),
    .st_o(dtr_st), .ov_o(dtr_ov)
  );

  evt_gexc #(.N_SRC(N_SRC)) u_gexc (
    .clk_i, .rst_ni,
    .src_i(gexc_src_i), .clr_i(gexc_clr),
    .src_o(gexc_q), .gexc_o(gexc_o)
  );

  evt_host_regs #(.N_CH(N_CH), .N_SRC(N_SRC)) u_regs (
    .clk_i, .rst_ni,
    .host_wr_i, .host_rd_i, .host_addr_i, .host_wdata_i,
    .irq_st_i(irq_st), .irq_ov_i(irq_ov), .dtr_st_i(dtr_st), .dtr_ov_i(dtr_ov),
    .gexc_src_i(gexc_q),
    .irq_st_clr_o(irq_st_clr), .irq_ov_clr_o(irq_ov_clr),
    .dtr_st_clr_o(dtr_st_clr), .dtr_ov_clr_o(dtr_ov_clr),
    .gexc_clr_o(gexc_clr),
    .host_rdata_o, .host_rvalid_o
  );

  assign irq_any_o = |irq_st;
  assign dtr_any_o = |dtr_st;

  p_any_after_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_set_i) |=> irq_any_o);

  p_dtr_any_after_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dtr_set_i) |=> dtr_any_o);
endmodule

// File: tb/evt_stat_top_tb_top.sv
`timescale 1ns/1ps
module evt_stat_top_tb_top;
  localparam int N_CH  = 32;
  localparam int N_SRC = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_CH-1:0]   irq_set = '0;
  logic [N_CH-1:0]   dtr_set = '0;
  logic [N_SRC-1:0]  gsrc = '0;
  logic              hwr = 1'b0;
  logic              hrd = 1'b0;
  logic [5:0]        haddr = '0;
  logic [31:0]       hwdata = '0;
  logic [31:0]       hrdata;
  logic              hrvalid, irq_any, dtr_any, gexc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  evt_stat_top #(.N_CH(N_CH), .N_SRC(N_SRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .irq_set_i(irq_set), .dtr_set_i(dtr_set), .gexc_src_i(gsrc),
    .host_wr_i(hwr), .host_rd_i(hrd), .host_addr_i(haddr), .host_wdata_i(hwdata),
    .host_rdata_o(hrdata), .host_rvalid_o(hrvalid),
    .irq_any_o(irq_any), .dtr_any_o(dtr_any), .gexc_o(gexc)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && hrvalid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %h expected none", hrdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (hrdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, hrdata, e);
        end
      end
    end
  end

  task automatic do_rd(input logic [5:0] a, input logic [31:0] e, input string t);
    hrd = 1'b1; haddr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    hrd = 1'b0;
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [31:0] d);
    hwr = 1'b1; haddr = a; hwdata = d;
    @(negedge clk);
    hwr = 1'b0; hwdata = '0;
  endtask

  task automatic pulse(input logic [N_CH-1:0] im, input logic [N_CH-1:0] dm,
                       input logic [N_SRC-1:0] gm);
    irq_set = im; dtr_set = dm; gsrc = gm;
    @(negedge clk);
    irq_set = '0; dtr_set = '0; gsrc = '0;
  endtask

  // set pulses and a host write in the same cycle
  task automatic pulse_wr(input logic [N_CH-1:0] im, input logic [N_SRC-1:0] gm,
                          input logic [5:0] a, input logic [31:0] d);
    irq_set = im; gsrc = gm; hwr = 1'b1; haddr = a; hwdata = d;
    @(negedge clk);
    irq_set = '0; gsrc = '0; hwr = 1'b0; hwdata = '0;
  endtask

  task automatic chk_lvl(input logic act, input logic e, input string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_lvl(irq_any, 1'b0, "R1 irq_any");
    chk_lvl(dtr_any, 1'b0, "R1 dtr_any");
    chk_lvl(gexc, 1'b0, "R1 gexc");
    do_rd(6'h05, 32'h0, "R1 ch5 word");
    do_rd(6'h20, 32'h0, "R1 irq st mirror");
    do_rd(6'h21, 32'h0, "R1 irq ov mirror");
    do_rd(6'h24, 32'h0, "R1 gexc word");

    // R2 / R10 first set
    pulse(32'h8, '0, '0);
    chk_lvl(irq_any, 1'b1, "R10 irq_any after set");
    chk_lvl(dtr_any, 1'b0, "R10 dtr_any untouched");
    do_rd(6'h03, 32'h1, "R2 ch3 status");
    // R3 reissue -> overflow
    pulse(32'h8, '0, '0);
    do_rd(6'h03, 32'h3, "R3 ch3 overflow");
    do_rd(6'h21, 32'h8, "R7 irq ov mirror");
    // R4 clear status keeps overflow
    do_wr(6'h03, 32'h1);
    do_rd(6'h03, 32'h2, "R4 ovf survives status clear");
    chk_lvl(irq_any, 1'b0, "R10 irq_any after clear");
    // R6 zero write
    do_wr(6'h03, 32'h0);
    do_rd(6'h03, 32'h2, "R6 zero write no effect");
    do_wr(6'h03, 32'h2);
    do_rd(6'h03, 32'h0, "R4 own ovf clear");

    // R5 same-cycle set and clear
    pulse(32'h80, '0, '0);
    pulse_wr(32'h80, '0, 6'h07, 32'h1);
    do_rd(6'h07, 32'h1, "R5 set wins, ovf stays 0");
    pulse(32'h80, '0, '0);
    do_rd(6'h07, 32'h3, "R3 ch7 overflow");
    pulse_wr(32'h80, '0, 6'h07, 32'h3);
    do_rd(6'h07, 32'h3, "R5 set wins, ovf stays 1");

    // R8 transfer requests
    pulse('0, 32'h400, '0);
    pulse('0, 32'h400, '0);
    chk_lvl(dtr_any, 1'b1, "R10 dtr_any");
    do_rd(6'h0A, 32'hC, "R8 ch10 dtr st+ov");
    do_rd(6'h22, 32'h400, "R7 dtr st mirror");
    do_rd(6'h23, 32'h400, "R7 dtr ov mirror");
    do_rd(6'h20, 32'h80, "R8 irq mirror independent");
    do_wr(6'h22, 32'h400);
    do_rd(6'h0A, 32'h8, "R7 mirror clear dtr st");
    chk_lvl(dtr_any, 1'b0, "R10 dtr_any cleared");
    do_wr(6'h23, 32'h400);
    do_rd(6'h0A, 32'h0, "R7 mirror clear dtr ov");

    // R7 boundary channels
    pulse(32'h8000_0001, '0, '0);
    do_rd(6'h20, 32'h8000_0081, "R7 ch0 ch31 mirror");
    do_rd(6'h1F, 32'h1, "R2 ch31 word");
    do_wr(6'h20, 32'hFFFF_FFFF);
    do_rd(6'h20, 32'h0, "R7 mirror clear all st");
    do_rd(6'h21, 32'h80, "R4 ov kept after mirror st clear");
    do_wr(6'h21, 32'hFFFF_FFFF);
    do_rd(6'h21, 32'h0, "R7 mirror clear all ov");

    // R9 global exception
    pulse('0, '0, 4'b0101);
    chk_lvl(gexc, 1'b1, "R9 gexc level");
    do_rd(6'h24, 32'h5, "R9 two sources");
    pulse('0, '0, 4'b0101);
    do_rd(6'h24, 32'h5, "R9 no overflow bits");
    pulse('0, '0, 4'b0010);
    do_rd(6'h24, 32'h7, "R9 combination");
    do_wr(6'h24, 32'h4);
    do_rd(6'h24, 32'h3, "R9 per-bit clear");
    pulse_wr('0, 4'b0001, 6'h24, 32'h1);
    do_rd(6'h24, 32'h3, "R9 source beats clear");
    do_wr(6'h24, 32'hF);
    do_rd(6'h24, 32'h0, "R9 all cleared");
    chk_lvl(gexc, 1'b0, "R9 gexc low");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R2 missing read data: actual %0d left expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule